// File: doc/BRIEF.md
# Stack Row Selector with Refresh Interleave

This block produces the row address for a small register stack kept in dynamic memory. It holds two up-only counters. The refresh counter names the next row that must be restored. The stack pointer names the current top of the stack. Three subcycle strobes from the instruction sequencer decide which counter drives the row output. A refresh-select strobe routes the refresh row onto the output. A pointer-select strobe routes the stack pointer. A refresh-end strobe closes the refresh access and moves the refresh counter to the next row. Between selections the output keeps the value it had.

All selection and holding uses edge-triggered registers on a fast system clock. No transparent latches are used, so the row value cannot depend on a race between a mux output and a latch gate. Every strobe and request may stay high for several system clock cycles. Each one acts only on its edge, which is found by comparison with a registered copy of the input. A call moves the pointer up one row. A return adds rows−1 to the pointer, which modulo the row count steps it back one row, so neither counter ever has to count down.

Top module: `stack_row_sel`

## Requirements
- R1: While reset (`rst_ni` low) is applied and on the first sample after it, `row_o` is 0 and `refresh_o` is 0. Both counters start from 0.
- R2: A rising edge of `sub_rfsh_sel_i` without a simultaneous rising edge of `sub_ptr_sel_i` loads the refresh counter value into `row_o`. The new value appears one system clock after the edge cycle.
- R3: A rising edge of `sub_ptr_sel_i` loads the stack pointer into `row_o` one clock later. The value loaded is the pointer as it stood before any call or return accepted in the same cycle.
- R4: In a cycle with no rising edge on either select strobe, `row_o` keeps its value. A select strobe held high for several cycles loads only once, and a counter change during that time does not reach the output.
- R5: When both select strobes rise in the same cycle, the stack pointer is loaded.
- R6: `refresh_o` is 1 in the cycle after any cycle in which `sub_rfsh_sel_i` or `sub_rfsh_end_i` is high, and 0 otherwise.
- R7: The refresh counter increases by one on each falling edge of `sub_rfsh_end_i` and wraps from 3 to 0.
- R8: A rising edge of `call_i` increases the stack pointer by one, wrapping from 3 to 0.
- R9: A rising edge of `ret_i` increases the stack pointer by three, so that 0 becomes 3.
- R10: When `call_i` and `ret_i` rise in the same cycle, the stack pointer ends unchanged.
- R11: A call or return request held high for several cycles moves the stack pointer only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| sub_rfsh_sel_i | input | 1 | Subcycle strobe that selects the refresh row |
| sub_rfsh_end_i | input | 1 | Subcycle strobe for the second refresh subcycle; its falling edge advances the refresh counter |
| sub_ptr_sel_i | input | 1 | Subcycle strobe that selects the stack pointer row |
| call_i | input | 1 | Call request; its rising edge pushes the pointer up one row |
| ret_i | input | 1 | Return request; its rising edge adds rows−1 to the pointer |
| row_o | output | ROW_W | Registered row address |
| refresh_o | output | 1 | Marks a refresh access in progress |

## Verification
The assertions check on every cycle how each edge moves the two counters, which source the row register loads, that the output holds between selections, that the refresh flag follows the strobes, and that an edge is reported for one cycle only. Other behaviour shows only through the bench's scenarios. This includes the actual row sequence the output walks through across many instruction cycles, the wrap of each counter, the value seen when a pointer load and a call share a cycle, and a counter change during a long select strobe staying off the output. Each of these can be seen only by comparing observed row values against a model.

// File: rtl/srs_pkg.sv
package srs_pkg;

    // Index of each level input inside the edge detector vector
    localparam int unsigned IDX_RFSH_SEL = 0;
    localparam int unsigned IDX_RFSH_OFF = 1;  // inverted refresh-end strobe
    localparam int unsigned IDX_PTR_SEL  = 2;
    localparam int unsigned IDX_CALL     = 3;
    localparam int unsigned IDX_RET      = 4;
    localparam int unsigned NUM_EDGES    = 5;

    // Reset value of the registered copies: the inverted strobe idles high
    localparam logic [NUM_EDGES-1:0] EDGE_RST = NUM_EDGES'(1) << IDX_RFSH_OFF;

endpackage

// File: rtl/srs_edge_det.sv
module srs_edge_det #(
    parameter int unsigned          N       = 1,
    parameter logic [N-1:0]         RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.prev <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_bit
        assign rise_o[g] = lvl_i[g] & ~st_q.prev[g];

        // R11: a level held high reports its edge for one cycle only
        p_rise_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rise_o[g] |=> !rise_o[g]);
    end

endmodule

// File: rtl/srs_up_counter.sv
module srs_up_counter #(
    parameter int unsigned W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] cnt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + step_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R7, R10: a zero step leaves the count untouched
    p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i == '0) |=> $stable(cnt_o));

endmodule

// File: rtl/stack_row_sel.sv
module stack_row_sel #(
    parameter int unsigned ROW_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sub_rfsh_sel_i,
    input  logic             sub_rfsh_end_i,
    input  logic             sub_ptr_sel_i,
    input  logic             call_i,
    input  logic             ret_i,
    output logic [ROW_W-1:0] row_o,
    output logic             refresh_o
);

    import srs_pkg::*;

    localparam int unsigned      ROWS      = 1 << ROW_W;
    localparam logic [ROW_W-1:0] STEP_ONE  = ROW_W'(1);
    localparam logic [ROW_W-1:0] STEP_BACK = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             refresh;
    } row_state_t;

    row_state_t st_d, st_q;

    logic [NUM_EDGES-1:0] lvl;
    logic [NUM_EDGES-1:0] rise;
    logic [ROW_W-1:0]     rfsh_cnt;
    logic [ROW_W-1:0]     ptr_cnt;
    logic [ROW_W-1:0]     rfsh_step;
    logic [ROW_W-1:0]     ptr_step;
    logic                 rfsh_rise;
    logic                 rfsh_done;
    logic                 ptr_rise;
    logic                 call_rise;
    logic                 ret_rise;

    // Level vector; the refresh-end strobe enters inverted so that its
    // falling edge shows up as a rising edge of this bit
    always_comb begin
        lvl               = '0;
        lvl[IDX_RFSH_SEL] = sub_rfsh_sel_i;
        lvl[IDX_RFSH_OFF] = ~sub_rfsh_end_i;
        lvl[IDX_PTR_SEL]  = sub_ptr_sel_i;
        lvl[IDX_CALL]     = call_i;
        lvl[IDX_RET]      = ret_i;
    end

    srs_edge_det #(
        .N       (NUM_EDGES),
        .RST_VAL (EDGE_RST)
    ) i_edges (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (lvl),
        .rise_o (rise)
    );

    assign rfsh_rise = rise[IDX_RFSH_SEL];
    assign rfsh_done = rise[IDX_RFSH_OFF];
    assign ptr_rise  = rise[IDX_PTR_SEL];
    assign call_rise = rise[IDX_CALL];
    assign ret_rise  = rise[IDX_RET];

    // Both counters only ever add; a return adds rows-1
    always_comb begin
        rfsh_step = rfsh_done ? STEP_ONE : '0;
        ptr_step  = (call_rise ? STEP_ONE : '0) + (ret_rise ? STEP_BACK : '0);
    end

    srs_up_counter #(.W(ROW_W)) i_rfsh_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (rfsh_step),
        .cnt_o  (rfsh_cnt)
    );

    srs_up_counter #(.W(ROW_W)) i_ptr_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (ptr_step),
        .cnt_o  (ptr_cnt)
    );

    // Registered row mux: pointer select wins, otherwise hold
    always_comb begin
        st_d         = st_q;
        st_d.refresh = sub_rfsh_sel_i | sub_rfsh_end_i;
        if (ptr_rise) begin
            st_d.row = ptr_cnt;
        end else if (rfsh_rise) begin
            st_d.row = rfsh_cnt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.row     <= '0;
            st_q.refresh <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_o     = st_q.row;
    assign refresh_o = st_q.refresh;

    p_load_rfsh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rfsh_rise && !ptr_rise) |=> (row_o == $past(rfsh_cnt)));

    p_load_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ptr_rise |=> (row_o == $past(ptr_cnt)));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rfsh_rise && !ptr_rise) |=> $stable(row_o));

    p_flag_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sub_rfsh_sel_i || sub_rfsh_end_i) |=> refresh_o);

    p_flag_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sub_rfsh_sel_i && !sub_rfsh_end_i) |=> !refresh_o);

    p_rfsh_adv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rfsh_done |=> (rfsh_cnt == ROW_W'($past(rfsh_cnt) + 1)));

    p_call_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (call_rise && !ret_rise) |=> (ptr_cnt == ROW_W'($past(ptr_cnt) + 1)));

    p_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_rise && !call_rise) |=> (ptr_cnt == ROW_W'($past(ptr_cnt) - 1)));

    p_both_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ret_rise && call_rise) |=> $stable(ptr_cnt));

endmodule

// File: tb/test_stack_row_sel.sv
module test_stack_row_sel;

    localparam int B_SEL  = 0;
    localparam int B_END  = 1;
    localparam int B_PTR  = 2;
    localparam int B_CALL = 3;
    localparam int B_RET  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] stim = '0;
    logic [1:0] row;
    logic       refresh;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [4:0] m_prev;
    logic [1:0] m_rfsh, m_ptr, m_row;
    logic       m_ref;

    always #2 clk = ~clk;  // 250 MHz

    stack_row_sel i_stack_row_sel (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .sub_rfsh_sel_i (stim[B_SEL]),
        .sub_rfsh_end_i (stim[B_END]),
        .sub_ptr_sel_i  (stim[B_PTR]),
        .call_i         (stim[B_CALL]),
        .ret_i          (stim[B_RET]),
        .row_o          (row),
        .refresh_o      (refresh)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, advance the model, compare outputs
    task automatic step(input logic [4:0] s);
        logic r_sel, r_ptr, f_end, r_call, r_ret;
        string tag;
        @(negedge clk);
        stim = s;
        @(posedge clk);
        #1;
        r_sel  = s[B_SEL]  & ~m_prev[B_SEL];
        r_ptr  = s[B_PTR]  & ~m_prev[B_PTR];
        f_end  = ~s[B_END] &  m_prev[B_END];
        r_call = s[B_CALL] & ~m_prev[B_CALL];
        r_ret  = s[B_RET]  & ~m_prev[B_RET];
        if (r_ptr && r_sel) tag = "R5";
        else if (r_ptr)     tag = "R3";
        else if (r_sel)     tag = "R2";
        else                tag = "R4";
        if (r_ptr)      m_row = m_ptr;
        else if (r_sel) m_row = m_rfsh;
        m_ref  = s[B_SEL] | s[B_END];
        m_rfsh = m_rfsh + (f_end ? 2'd1 : 2'd0);
        m_ptr  = m_ptr + (r_call ? 2'd1 : 2'd0) + (r_ret ? 2'd3 : 2'd0);
        m_prev = s;
        chk(tag, row, m_row);
        chk("R6", refresh, m_ref);
    endtask

    task automatic pulse(input logic [4:0] s);
        step(s);
        step(5'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_prev = '0; m_rfsh = '0; m_ptr = '0; m_row = '0; m_ref = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", row, 0);
        chk("R1", refresh, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(5'b0);
        chk("R1", row, 0);

        // R2: first refresh selection shows row 0
        pulse(5'b1 << B_SEL);
        chk("R2", row, 0);

        // R7: refresh counter walks 1,2,3 and wraps to 0
        for (int k = 1; k <= 4; k++) begin
            step(5'b1 << B_END);
            chk("R6", refresh, 1);
            step(5'b0);
            pulse(5'b1 << B_SEL);
            chk("R7", row, k % 4);
        end

        // R8: call then pointer select, then wrap
        pulse(5'b1 << B_CALL);
        pulse(5'b1 << B_PTR);
        chk("R8", row, 1);
        for (int k = 0; k < 3; k++) pulse(5'b1 << B_CALL);
        pulse(5'b1 << B_PTR);
        chk("R8", row, 0);

        // R9: return steps back from 0 to 3
        pulse(5'b1 << B_RET);
        pulse(5'b1 << B_PTR);
        chk("R9", row, 3);

        // R10: call and return together leave pointer at 3
        pulse((5'b1 << B_CALL) | (5'b1 << B_RET));
        pulse(5'b1 << B_PTR);
        chk("R10", row, 3);

        // R11: call held five cycles moves the pointer once (3 -> 0)
        for (int k = 0; k < 5; k++) step(5'b1 << B_CALL);
        step(5'b0);
        pulse(5'b1 << B_PTR);
        chk("R11", row, 0);

        // R5: refresh counter now 1, pointer 0; simultaneous selects
        pulse(5'b1 << B_END);
        pulse((5'b1 << B_SEL) | (5'b1 << B_PTR));
        chk("R5", row, 0);

        // R4: long refresh select while the refresh counter advances
        step(5'b1 << B_SEL);
        step((5'b1 << B_SEL) | (5'b1 << B_END));
        step(5'b1 << B_SEL);
        step(5'b1 << B_SEL);
        chk("R4", row, 1);
        step(5'b0);
        chk("R6", refresh, 0);
        pulse(5'b1 << B_SEL);
        chk("R2", row, 2);

        // R3: pointer select sharing a cycle with a call sees the old pointer
        step((5'b1 << B_CALL) | (5'b1 << B_PTR));
        chk("R3", row, 0);
        step(5'b0);
        pulse(5'b1 << B_PTR);
        chk("R3", row, 1);

        // Random strobe traffic checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] s;
            for (int b = 0; b < 5; b++) s[b] = (($urandom % 3) == 0);
            step(s);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule